// File: doc/BRIEF.md
# Speculative Fetch Address Generator

This block produces the memory address for a small 8-bit processor whose bus takes one access per clock. The address comes from a dedicated bus register that is separate from the program counter. In every cycle the block chooses the bus register's value for the next cycle. If the decoder has not given a decision, it assumes the fetch stays sequential and advances. One incrementer computes the successor once, and that value loads the program counter and the bus register together. The byte returned for an instruction fetch is captured at the end of its cycle. It is then available for decoding during the following cycle, while the next sequential address is already on the bus.

The decoder reports each decision in the cycle after it receives the byte. If it reports a taken branch, the sequential fetch that is in flight is wrong. The block discards that byte. It then spends one recovery cycle with the read strobe low and the branch target on the bus, and reads the target in the cycle after that. A not-taken decision costs nothing. A decode that needs a data access places the operand address on the bus for one cycle. The byte from that access is not treated as an instruction. Sequential fetching then resumes after the last instruction address.

Top module: `fetch_addr_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `mem_addr` equals RESET_VEC (default 16'hFFFC) with `mem_rd` low and `instr` at 8'h00. The next cycle reads RESET_VEC with `mem_rd` high.
- R2: After an instruction fetch cycle with `dec_valid` low, the next cycle drives the previous address plus one, modulo 2^AW (16'hFFFF is followed by 16'h0000), with `mem_rd` high.
- R3: A decision with `dec_valid`=1, `br_taken`=0 and `opnd_req`=0 behaves exactly as R2 and inserts no idle cycle.
- R4: If `dec_valid`=1 and `br_taken`=1 in a reading cycle N, then cycle N+1 drives `br_target` with `mem_rd` low, cycle N+2 drives `br_target` with `mem_rd` high, and cycle N+3 drives `br_target`+1. This holds even when the target equals the sequential address.
- R5: The byte present in a cycle that resolves a taken branch is not latched. Neither is the byte present in a cycle with `mem_rd` low. In both cases `instr` keeps its value.
- R6: In an instruction fetch cycle that does not resolve a taken branch, `mem_data` is latched at the closing clock edge and appears on `instr` for the whole next cycle.
- R7: If `dec_valid`=1, `opnd_req`=1 and `br_taken`=0, the next cycle drives `opnd_addr` with `mem_rd` high. Its byte does not change `instr`. The cycle after that drives the last instruction fetch address plus one.
- R8: A taken branch wins over a simultaneous operand request. All decode inputs are ignored during a recovery cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_valid | input | 1 | Decoder has resolved the byte latched in the previous cycle |
| br_taken | input | 1 | With dec_valid: branch is taken |
| opnd_req | input | 1 | With dec_valid: a data access is needed next |
| br_target | input | AW | Branch destination address |
| opnd_addr | input | AW | Data access address |
| mem_data | input | DW | Byte returned for the current address |
| mem_addr | output | AW | Registered bus address |
| mem_rd | output | 1 | Read strobe for the current address |
| instr | output | DW | Last latched instruction byte |

## Verification
A taken branch can arrive in the same cycle as an operand request. It can also arrive while a recovery cycle is already under way, which is the moment when the decode inputs must be ignored. The vector table provokes both cases: one row raises branch and operand request together, and another raises a new branch during a bubble. Each is judged by comparing the address, the strobe and the latched byte cycle by cycle against hand-derived values. The branch target must appear after exactly one bubble, the operand address must not appear, and the discarded bytes must never show up on `instr`.

// File: rtl/fag_pkg.sv
package fag_pkg;
    typedef enum logic [1:0] {
        SEL_SEQ    = 2'd0,
        SEL_BRANCH = 2'd1,
        SEL_OPND   = 2'd2,
        SEL_HOLD   = 2'd3
    } sel_e;
endpackage

// File: rtl/fag_incr.sv
module fag_incr #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] y
);
    assign y = a + {{(W-1){1'b0}}, 1'b1};
endmodule

// File: rtl/fag_sel.sv
module fag_sel
    import fag_pkg::*;
(
    input  logic dec_valid,
    input  logic br_taken,
    input  logic opnd_req,
    input  logic recov,
    output sel_e sel
);
    // priority: recovery, taken branch, operand access, sequential guess
    always_comb begin
        if (recov)                        sel = SEL_HOLD;
        else if (dec_valid && br_taken)   sel = SEL_BRANCH;
        else if (dec_valid && opnd_req)   sel = SEL_OPND;
        else                              sel = SEL_SEQ;
    end
endmodule

// File: rtl/fag_addr_mux.sv
module fag_addr_mux
    import fag_pkg::*;
#(
    parameter int AW = 16
) (
    input  sel_e          sel,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] pc_inc,
    input  logic [AW-1:0] target,
    input  logic [AW-1:0] opnd,
    output logic [AW-1:0] addr_nxt,
    output logic [AW-1:0] pc_nxt,
    output logic          rd_nxt,
    output logic          recov_nxt,
    output logic          ifetch_nxt
);
    always_comb begin
        addr_nxt   = pc_inc;
        pc_nxt     = pc_inc;
        rd_nxt     = 1'b1;
        recov_nxt  = 1'b0;
        ifetch_nxt = 1'b1;
        case (sel)
            SEL_SEQ: begin
                addr_nxt = pc_inc;
                pc_nxt   = pc_inc;
            end
            SEL_BRANCH: begin
                addr_nxt  = target;
                pc_nxt    = target;
                rd_nxt    = 1'b0;
                recov_nxt = 1'b1;
            end
            SEL_OPND: begin
                addr_nxt   = opnd;
                pc_nxt     = pc;
                ifetch_nxt = 1'b0;
            end
            default: begin
                addr_nxt = pc;
                pc_nxt   = pc;
            end
        endcase
    end
endmodule

// File: rtl/fetch_addr_gen.sv
module fetch_addr_gen
    import fag_pkg::*;
#(
    parameter int            AW        = 16,
    parameter int            DW        = 8,
    parameter logic [AW-1:0] RESET_VEC = 16'hFFFC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_valid,
    input  logic          br_taken,
    input  logic          opnd_req,
    input  logic [AW-1:0] br_target,
    input  logic [AW-1:0] opnd_addr,
    input  logic [DW-1:0] mem_data,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic [DW-1:0] instr
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [AW-1:0] pc;
        logic          rd;
        logic          recov;
        logic          ifetch;
        logic [DW-1:0] ir;
    } state_t;

    state_t s_q, s_d;

    sel_e          sel;
    logic [AW-1:0] pc_inc;
    logic [AW-1:0] addr_nxt, pc_nxt;
    logic          rd_nxt, recov_nxt, ifetch_nxt;

    fag_sel u_sel (
        .dec_valid (dec_valid),
        .br_taken  (br_taken),
        .opnd_req  (opnd_req),
        .recov     (s_q.recov),
        .sel       (sel)
    );

    // one shared successor feeds both the PC and the bus register
    fag_incr #(.W(AW)) u_incr (
        .a (s_q.pc),
        .y (pc_inc)
    );

    fag_addr_mux #(.AW(AW)) u_mux (
        .sel        (sel),
        .pc         (s_q.pc),
        .pc_inc     (pc_inc),
        .target     (br_target),
        .opnd       (opnd_addr),
        .addr_nxt   (addr_nxt),
        .pc_nxt     (pc_nxt),
        .rd_nxt     (rd_nxt),
        .recov_nxt  (recov_nxt),
        .ifetch_nxt (ifetch_nxt)
    );

    always_comb begin
        s_d        = s_q;
        s_d.addr   = addr_nxt;
        s_d.pc     = pc_nxt;
        s_d.rd     = rd_nxt;
        s_d.recov  = recov_nxt;
        s_d.ifetch = ifetch_nxt;
        // a byte fetched down a path the branch just abandoned is dropped
        if (s_q.rd && s_q.ifetch && (sel != SEL_BRANCH)) begin
            s_d.ir = mem_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.addr   <= RESET_VEC;
            s_q.pc     <= RESET_VEC;
            s_q.rd     <= 1'b0;
            s_q.recov  <= 1'b1;
            s_q.ifetch <= 1'b1;
            s_q.ir     <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_addr = s_q.addr;
    assign mem_rd   = s_q.rd;
    assign instr    = s_q.ir;
endmodule

// File: rtl/fag_checker.sv
module fag_checker #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dec_valid,
    input logic          br_taken,
    input logic          opnd_req,
    input logic [AW-1:0] br_target,
    input logic [AW-1:0] opnd_addr,
    input logic [DW-1:0] mem_data,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rd,
    input logic [DW-1:0] instr,
    input logic          ifetch
);
    // a strobe-low cycle is always followed by a read of the same address
    assert_bubble_then_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd |=> (mem_rd && mem_addr == $past(mem_addr)));

    assert_seq_guess_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && ifetch && !dec_valid) |=> (mem_rd && mem_addr == AW'($past(mem_addr) + 1'b1)));

    assert_not_taken_no_bubble_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && ifetch && dec_valid && !br_taken && !opnd_req)
            |=> (mem_rd && mem_addr == AW'($past(mem_addr) + 1'b1)));

    assert_taken_bubble_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && dec_valid && br_taken) |=> (!mem_rd && mem_addr == $past(br_target)));

    assert_discard_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && dec_valid && br_taken) |=> $stable(instr));

    assert_discard_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd |=> $stable(instr));

    assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && ifetch && !(dec_valid && br_taken)) |=> (instr == $past(mem_data)));

    assert_operand_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && dec_valid && opnd_req && !br_taken) |=> (mem_rd && mem_addr == $past(opnd_addr)));
endmodule

bind fetch_addr_gen fag_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec_valid (dec_valid),
    .br_taken  (br_taken),
    .opnd_req  (opnd_req),
    .br_target (br_target),
    .opnd_addr (opnd_addr),
    .mem_data  (mem_data),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .instr     (instr),
    .ifetch    (s_q.ifetch)
);

// File: tb/fetch_addr_gen_bench.sv
`timescale 1ns/1ps
module fetch_addr_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_valid = 1'b0, br_taken = 1'b0, opnd_req = 1'b0;
    logic [15:0] br_target = '0, opnd_addr = '0;
    logic [7:0]  mem_data = '0;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  instr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fetch_addr_gen u_fetch_addr_gen (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .br_taken(br_taken),
        .opnd_req(opnd_req), .br_target(br_target), .opnd_addr(opnd_addr),
        .mem_data(mem_data), .mem_addr(mem_addr), .mem_rd(mem_rd), .instr(instr)
    );

    typedef struct packed {
        logic        dv;
        logic        bt;
        logic        oq;
        logic [15:0] tgt;
        logic [15:0] oa;
        logic [7:0]  data;
        logic [15:0] e_addr;
        logic        e_rd;
        logic [7:0]  e_instr;
    } row_t;

    // inputs applied in a cycle, outputs expected in that same cycle
    localparam int NROW = 19;
    localparam row_t TBL [NROW] = '{
        '{1'b0,1'b0,1'b0,16'h0000,16'h0000,8'h00, 16'hFFFC,1'b0,8'h00}, // R1 first cycle
        '{1'b0,1'b0,1'b0,16'h0000,16'h0000,8'hA1, 16'hFFFC,1'b1,8'h00}, // R1 vector read
        '{1'b1,1'b0,1'b0,16'h0000,16'h0000,8'hA2, 16'hFFFD,1'b1,8'hA1}, // R2, R3 not taken
        '{1'b0,1'b0,1'b0,16'h0000,16'h0000,8'hA3, 16'hFFFE,1'b1,8'hA2}, // R3 no bubble
        '{1'b0,1'b0,1'b0,16'h0000,16'h0000,8'hA4, 16'hFFFF,1'b1,8'hA3}, // R6
        '{1'b1,1'b1,1'b0,16'h1234,16'h0000,8'hA5, 16'h0000,1'b1,8'hA4}, // R2 wrap, R4 taken
        '{1'b1,1'b1,1'b1,16'h5555,16'h0777,8'hEE, 16'h1234,1'b0,8'hA4}, // R4 bubble, R5, R8 ignored
        '{1'b0,1'b0,1'b0,16'h0000,16'h0000,8'hB1, 16'h1234,1'b1,8'hA4}, // R4 target read, R5
        '{1'b1,1'b0,1'b1,16'h0000,16'h0040,8'hB2, 16'h1235,1'b1,8'hB1}, // R7 request
        '{1'b0,1'b0,1'b0,16'h0000,16'h0000,8'hD0, 16'h0040,1'b1,8'hB2}, // R7 operand cycle
        '{1'b0,1'b0,1'b0,16'h0000,16'h0000,8'hB3, 16'h1236,1'b1,8'hB2}, // R7 resume, not latched
        '{1'b1,1'b1,1'b1,16'h2000,16'h0999,8'hB4, 16'h1237,1'b1,8'hB3}, // R8 branch beats operand
        '{1'b0,1'b0,1'b0,16'h0000,16'h0000,8'hEE, 16'h2000,1'b0,8'hB3}, // R8, R5
        '{1'b0,1'b0,1'b0,16'h0000,16'h0000,8'hC1, 16'h2000,1'b1,8'hB3}, // R4
        '{1'b0,1'b0,1'b0,16'h0000,16'h0000,8'hC2, 16'h2001,1'b1,8'hC1}, // R4 target+1
        '{1'b1,1'b1,1'b0,16'h2003,16'h0000,8'hC3, 16'h2002,1'b1,8'hC2}, // R4 target == sequential
        '{1'b0,1'b0,1'b0,16'h0000,16'h0000,8'h00, 16'h2003,1'b0,8'hC2}, // R4 still bubbles
        '{1'b0,1'b0,1'b0,16'h0000,16'h0000,8'hC4, 16'h2003,1'b1,8'hC2}, // R5 C3 dropped
        '{1'b0,1'b0,1'b0,16'h0000,16'h0000,8'h00, 16'h2004,1'b1,8'hC4}  // R6
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        dec_valid = 1'b0; br_taken = 1'b0; opnd_req = 1'b0;
        br_target = '0; opnd_addr = '0; mem_data = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 addr in reset", 32'(mem_addr), 32'hFFFC);
        chk("R1 rd in reset", 32'(mem_rd), 32'h0);
        rst_n = 1'b1;
        for (int i = 0; i < NROW; i++) begin
            chk($sformatf("row %0d addr", i), 32'(mem_addr), 32'(TBL[i].e_addr));
            chk($sformatf("row %0d rd", i), 32'(mem_rd), 32'(TBL[i].e_rd));
            chk($sformatf("row %0d instr", i), 32'(instr), 32'(TBL[i].e_instr));
            dec_valid = TBL[i].dv;
            br_taken  = TBL[i].bt;
            opnd_req  = TBL[i].oq;
            br_target = TBL[i].tgt;
            opnd_addr = TBL[i].oa;
            mem_data  = TBL[i].data;
            @(negedge clk);
        end
        // R1: reset in the middle of a run
        idle_inputs();
        rst_n = 1'b0;
        #1;
        chk("R1 mid-run reset addr", 32'(mem_addr), 32'hFFFC);
        chk("R1 mid-run reset rd", 32'(mem_rd), 32'h0);
        chk("R1 mid-run reset instr", 32'(instr), 32'h00);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 release rd", 32'(mem_rd), 32'h0);
        @(negedge clk);
        chk("R1 vector addr", 32'(mem_addr), 32'hFFFC);
        chk("R1 vector rd", 32'(mem_rd), 32'h1);
        mem_data = 8'h5A;
        @(negedge clk);
        chk("R2 after vector", 32'(mem_addr), 32'hFFFD);
        chk("R6 vector byte", 32'(instr), 32'h5A);
        // R7 then R4 back to back: taken branch in the operand cycle
        dec_valid = 1'b1; opnd_req = 1'b1; opnd_addr = 16'h0300; mem_data = 8'h61;
        @(negedge clk);
        chk("R7 operand addr", 32'(mem_addr), 32'h0300);
        dec_valid = 1'b1; br_taken = 1'b1; opnd_req = 1'b0; br_target = 16'h4000; mem_data = 8'h99;
        @(negedge clk);
        idle_inputs();
        chk("R4 bubble addr", 32'(mem_addr), 32'h4000);
        chk("R4 bubble rd", 32'(mem_rd), 32'h0);
        chk("R5 operand byte not latched", 32'(instr), 32'h61);
        @(negedge clk);
        chk("R4 target read", 32'(mem_rd), 32'h1);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 200000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule